// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers the level interrupt lines raised by the memory protection checkers, the peripheral protection checkers and the bus-master security checkers of a subsystem and presents them to software as packed 32-bit status words. Each source class has a fixed home inside its word: internal sources fill the low half and expansion sources fill the upper half, at positions that software and the upstream checkers both decode.

Software reaches the block through a simple single-cycle register port (offset, write data, write enable, combinational read data). Enable registers are forwarded bit by bit to the upstream checkers as per-source enable lines. Clear registers do more than drop a bit locally: writing one produces a one-cycle clear strobe toward each selected source, so the checker that holds the real interrupt state can release it. The bus-master checker group also gets a combined interrupt output and a software-owned per-source non-secure selection. A bridge-error enable register and an always-zero bridge status word are kept so that software sees a stable map.

Top module: `secirq_agg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every readable register reads 0 and every clear, enable, non-secure and combined interrupt output is 0.
- R2: The memory-protection status word (offset 0x00) holds internal input n at bit n and expansion input n at bit 16+n, sampled one clock after the inputs; other bits read 0.
- R3: The peripheral-protection status word (offset 0x04) holds the two internal sources at bits 0 and 1, APB-side expansion source i at bit 4+i and AHB-side expansion source i at bit 20+i (mask 0x00F000F3 at default sizes), sampled one clock after the inputs.
- R4: A write to offset 0x08 makes the status bits selected by (wdata & mask) read 0 in the following cycle and raises the clear output of exactly those sources for that one cycle; bits outside the mask have no effect; the register reads 0.
- R5: A write to offset 0x0C stores (wdata & mask), which reads back at 0x0C, and each source's enable output equals its bit.
- R6: The bus-master status word (offset 0x10) holds expansion input n at bit 16+n, sampled one clock after the input; bits 15:0 read 0.
- R7: Offset 0x18 stores the bus-master enable bits 16 and up; the combined interrupt output is high exactly when some status bit and the same enable bit are both set.
- R8: A write to offset 0x14 raises clear output n for one cycle when wdata bit 16+n is set; the register reads 0.
- R9: Offset 0x1C stores bits 16 and up; non-secure output n equals stored bit 16+n.
- R10: The bridge enable register (offset 0x24) keeps only bits 31:16; the bridge status word (offset 0x20) always reads 0 and ignores writes.
- R11: Writes to status offsets or to unmapped offsets change no register or output; unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regOffset | input | 8 | Register byte offset |
| regWdata | input | 32 | Write data |
| regWen | input | 1 | Write enable, one write per cycle |
| regRdata | output | 32 | Read data for regOffset |
| mpcIntIn | input | NUM_MPC_INT | Internal memory-protection interrupt levels |
| mpcExpIn | input | NUM_MPC_EXP | Expansion memory-protection interrupt levels |
| ppcIrqIn | input | 2+NUM_APB_EXP+NUM_AHB_EXP | Peripheral-protection interrupt levels: internal, APB-side, AHB-side |
| ppcClrOut | output | 2+NUM_APB_EXP+NUM_AHB_EXP | Per-source clear strobes |
| ppcEnOut | output | 2+NUM_APB_EXP+NUM_AHB_EXP | Per-source enable lines |
| mscExpIn | input | NUM_MSC_EXP | Bus-master checker interrupt levels |
| mscClrOut | output | NUM_MSC_EXP | Per-source clear strobes |
| mscNsOut | output | NUM_MSC_EXP | Per-source non-secure selections |
| mscIrq | output | 1 | Combined bus-master checker interrupt |

## Verification
Status packing is tried with walking single bits, all-ones and sparse alternating patterns, which separates a shifted or swapped bit home from a correct one and shows the gaps in the peripheral word stay empty. Clear writes are issued with the source still asserted, with selectors falling only outside the mask, and back to back with enable changes, telling a one-cycle strobe from a held one and a masked clear from an unmasked one. The combined interrupt is driven with status and enable bits that overlap and bits that do not, so an OR of either word alone is caught. A reference model compares every output and the read data on every clock.

// File: rtl/secirq_pkg.sv
package secirq_pkg;
  localparam int REG_W  = 32;
  localparam int OFFS_W = 8;

  localparam logic [OFFS_W-1:0] OFS_MPC_STAT = 8'h00;
  localparam logic [OFFS_W-1:0] OFS_PPC_STAT = 8'h04;
  localparam logic [OFFS_W-1:0] OFS_PPC_CLR  = 8'h08;
  localparam logic [OFFS_W-1:0] OFS_PPC_EN   = 8'h0C;
  localparam logic [OFFS_W-1:0] OFS_MSC_STAT = 8'h10;
  localparam logic [OFFS_W-1:0] OFS_MSC_CLR  = 8'h14;
  localparam logic [OFFS_W-1:0] OFS_MSC_EN   = 8'h18;
  localparam logic [OFFS_W-1:0] OFS_MSC_NS   = 8'h1C;
  localparam logic [OFFS_W-1:0] OFS_BRG_STAT = 8'h20;
  localparam logic [OFFS_W-1:0] OFS_BRG_EN   = 8'h24;

  typedef enum logic [2:0] {
    RD_NONE, RD_MPC, RD_PPC_STAT, RD_PPC_EN,
    RD_MSC_STAT, RD_MSC_EN, RD_MSC_NS, RD_BRG_EN
  } rdSel_e;

  typedef struct packed {
    logic   wrPpcClr;
    logic   wrPpcEn;
    logic   wrMscClr;
    logic   wrMscEn;
    logic   wrMscNs;
    logic   wrBrgEn;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/secirq_ctrl.sv
module secirq_ctrl
  import secirq_pkg::*;
(
  input  logic [OFFS_W-1:0] regOffset,
  input  logic              regWen,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    unique case (regOffset)
      OFS_MPC_STAT: strobe.rdSel = RD_MPC;
      OFS_PPC_STAT: strobe.rdSel = RD_PPC_STAT;
      OFS_PPC_CLR:  strobe.wrPpcClr = regWen;
      OFS_PPC_EN:   begin strobe.rdSel = RD_PPC_EN; strobe.wrPpcEn = regWen; end
      OFS_MSC_STAT: strobe.rdSel = RD_MSC_STAT;
      OFS_MSC_CLR:  strobe.wrMscClr = regWen;
      OFS_MSC_EN:   begin strobe.rdSel = RD_MSC_EN; strobe.wrMscEn = regWen; end
      OFS_MSC_NS:   begin strobe.rdSel = RD_MSC_NS; strobe.wrMscNs = regWen; end
      OFS_BRG_EN:   begin strobe.rdSel = RD_BRG_EN; strobe.wrBrgEn = regWen; end
      default:      strobe.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/secirq_dp.sv
module secirq_dp
  import secirq_pkg::*;
#(
  parameter int NUM_MPC_INT = 2,
  parameter int NUM_MPC_EXP = 4,
  parameter int NUM_APB_EXP = 4,
  parameter int NUM_AHB_EXP = 4,
  parameter int NUM_MSC_EXP = 4,
  localparam int NUM_PPC = 2 + NUM_APB_EXP + NUM_AHB_EXP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobe_t         strobe,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic [NUM_MPC_INT-1:0] mpcIntIn,
  input  logic [NUM_MPC_EXP-1:0] mpcExpIn,
  input  logic [NUM_PPC-1:0] ppcIrqIn,
  output logic [NUM_PPC-1:0] ppcClrOut,
  output logic [NUM_PPC-1:0] ppcEnOut,
  input  logic [NUM_MSC_EXP-1:0] mscExpIn,
  output logic [NUM_MSC_EXP-1:0] mscClrOut,
  output logic [NUM_MSC_EXP-1:0] mscNsOut,
  output logic               mscIrq
);
  localparam int HALF = REG_W / 2;

  function automatic int ppcPos(int k);
    if (k < 2)                return k;
    if (k < 2 + NUM_APB_EXP)  return 4 + (k - 2);
    return 20 + (k - 2 - NUM_APB_EXP);
  endfunction

  function automatic logic [REG_W-1:0] ppcMaskF();
    logic [REG_W-1:0] m = '0;
    for (int k = 0; k < NUM_PPC; k++) m[ppcPos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] PPC_MASK = ppcMaskF();
  localparam logic [REG_W-1:0] MSC_MASK =
    {{(HALF-NUM_MSC_EXP){1'b0}}, {NUM_MSC_EXP{1'b1}}, {HALF{1'b0}}};
  localparam logic [REG_W-1:0] BRG_MASK = {{HALF{1'b1}}, {HALF{1'b0}}};

  logic [REG_W-1:0] mpcStat, ppcStat, ppcEn, mscStat, mscEn, mscNs, brgEn;
  logic [REG_W-1:0] mpcNext, ppcNext, mscNext, ppcClrMask;
  logic [NUM_PPC-1:0] ppcClrSel, ppcClrQ;
  logic [NUM_MSC_EXP-1:0] mscClrQ;

  assign ppcClrMask = regWdata & PPC_MASK;

  always_comb begin
    mpcNext = '0;
    mpcNext[NUM_MPC_INT-1:0]    = mpcIntIn;
    mpcNext[HALF +: NUM_MPC_EXP] = mpcExpIn;
    mscNext = '0;
    mscNext[HALF +: NUM_MSC_EXP] = mscExpIn;
  end

  for (genvar i = 0; i < NUM_PPC; i++) begin : g_ppc
    localparam int POS = ppcPos(i);
    assign ppcClrSel[i] = regWdata[POS];
    assign ppcEnOut[i]  = ppcEn[POS];
  end

  always_comb begin
    ppcNext = '0;
    for (int k = 0; k < NUM_PPC; k++) ppcNext[ppcPos(k)] = ppcIrqIn[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpcStat <= '0;
      ppcStat <= '0;
      mscStat <= '0;
      ppcEn   <= '0;
      mscEn   <= '0;
      mscNs   <= '0;
      brgEn   <= '0;
      ppcClrQ <= '0;
      mscClrQ <= '0;
    end else begin
      mpcStat <= mpcNext;
      mscStat <= mscNext;
      ppcStat <= strobe.wrPpcClr ? (ppcNext & ~ppcClrMask) : ppcNext;
      ppcClrQ <= strobe.wrPpcClr ? ppcClrSel : '0;
      mscClrQ <= strobe.wrMscClr ? regWdata[HALF +: NUM_MSC_EXP] : '0;
      if (strobe.wrPpcEn) ppcEn <= regWdata & PPC_MASK;
      if (strobe.wrMscEn) mscEn <= regWdata & MSC_MASK;
      if (strobe.wrMscNs) mscNs <= regWdata & MSC_MASK;
      if (strobe.wrBrgEn) brgEn <= regWdata & BRG_MASK;
    end
  end

  assign ppcClrOut = ppcClrQ;
  assign mscClrOut = mscClrQ;
  assign mscNsOut  = mscNs[HALF +: NUM_MSC_EXP];
  assign mscIrq    = |(mscStat & mscEn);

  always_comb begin
    unique case (strobe.rdSel)
      RD_MPC:      regRdata = mpcStat;
      RD_PPC_STAT: regRdata = ppcStat;
      RD_PPC_EN:   regRdata = ppcEn;
      RD_MSC_STAT: regRdata = mscStat;
      RD_MSC_EN:   regRdata = mscEn;
      RD_MSC_NS:   regRdata = mscNs;
      RD_BRG_EN:   regRdata = brgEn;
      default:     regRdata = '0;
    endcase
  end

  // R4: a clear strobe only follows a clear write
  p_ppc_clr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ppcClrOut) |-> $past(strobe.wrPpcClr));
  // R4: selected status bits read zero after the clear write
  p_ppc_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrPpcClr |=> ((ppcStat & $past(ppcClrMask)) == '0));
  // R8: bus-master clear strobes only follow a clear write
  p_msc_clr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|mscClrOut) |-> $past(strobe.wrMscClr));
  // R7: the combined interrupt needs some enable bit
  p_msc_irq_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mscIrq |-> (mscEn != '0));
endmodule

// File: rtl/secirq_agg.sv
module secirq_agg
  import secirq_pkg::*;
#(
  parameter int NUM_MPC_INT = 2,
  parameter int NUM_MPC_EXP = 4,
  parameter int NUM_APB_EXP = 4,
  parameter int NUM_AHB_EXP = 4,
  parameter int NUM_MSC_EXP = 4,
  localparam int NUM_PPC = 2 + NUM_APB_EXP + NUM_AHB_EXP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             regOffset,
  input  logic [31:0]            regWdata,
  input  logic                   regWen,
  output logic [31:0]            regRdata,
  input  logic [NUM_MPC_INT-1:0] mpcIntIn,
  input  logic [NUM_MPC_EXP-1:0] mpcExpIn,
  input  logic [NUM_PPC-1:0]     ppcIrqIn,
  output logic [NUM_PPC-1:0]     ppcClrOut,
  output logic [NUM_PPC-1:0]     ppcEnOut,
  input  logic [NUM_MSC_EXP-1:0] mscExpIn,
  output logic [NUM_MSC_EXP-1:0] mscClrOut,
  output logic [NUM_MSC_EXP-1:0] mscNsOut,
  output logic                   mscIrq
);
  regStrobe_t strobe;

  secirq_ctrl ctrl_i (
    .regOffset (regOffset),
    .regWen    (regWen),
    .strobe    (strobe)
  );

  secirq_dp #(
    .NUM_MPC_INT (NUM_MPC_INT),
    .NUM_MPC_EXP (NUM_MPC_EXP),
    .NUM_APB_EXP (NUM_APB_EXP),
    .NUM_AHB_EXP (NUM_AHB_EXP),
    .NUM_MSC_EXP (NUM_MSC_EXP)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .mpcIntIn  (mpcIntIn),
    .mpcExpIn  (mpcExpIn),
    .ppcIrqIn  (ppcIrqIn),
    .ppcClrOut (ppcClrOut),
    .ppcEnOut  (ppcEnOut),
    .mscExpIn  (mscExpIn),
    .mscClrOut (mscClrOut),
    .mscNsOut  (mscNsOut),
    .mscIrq    (mscIrq)
  );

  // R10: bridge status reads zero
  p_brg_stat_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (regOffset == OFS_BRG_STAT) |-> (regRdata == '0));
  // R10: bridge enable low half never reads set
  p_brg_en_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (regOffset == OFS_BRG_EN) |-> (regRdata[15:0] == '0));
  // R11: unmapped offsets read zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (regOffset > OFS_BRG_EN) |-> (regRdata == '0));
endmodule

// File: tb/secirq_agg_tb_top.sv
module secirq_agg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  regOffset = '0;
  logic [31:0] regWdata = '0;
  logic        regWen = 1'b0;
  logic [31:0] regRdata;
  logic [1:0]  mpcIntIn = '0;
  logic [3:0]  mpcExpIn = '0;
  logic [9:0]  ppcIrqIn = '0;
  logic [9:0]  ppcClrOut, ppcEnOut;
  logic [3:0]  mscExpIn = '0;
  logic [3:0]  mscClrOut, mscNsOut;
  logic        mscIrq;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  secirq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .regOffset(regOffset), .regWdata(regWdata),
    .regWen(regWen), .regRdata(regRdata), .mpcIntIn(mpcIntIn),
    .mpcExpIn(mpcExpIn), .ppcIrqIn(ppcIrqIn), .ppcClrOut(ppcClrOut),
    .ppcEnOut(ppcEnOut), .mscExpIn(mscExpIn), .mscClrOut(mscClrOut),
    .mscNsOut(mscNsOut), .mscIrq(mscIrq)
  );

  // reference model state
  logic [31:0] mMpc, mPpc, mPpcEn, mMsc, mMscEn, mMscNs, mBrg, pIn, cMask;
  logic [9:0]  mPpcClr;
  logic [3:0]  mMscClr;

  function automatic int bpos(int i);
    if (i < 2) return i;
    if (i < 6) return i + 2;
    return i + 14;
  endfunction

  function automatic logic [31:0] modelRead(logic [7:0] off);
    case (off)
      8'h00: return mMpc;
      8'h04: return mPpc;
      8'h0C: return mPpcEn;
      8'h10: return mMsc;
      8'h18: return mMscEn;
      8'h1C: return mMscNs;
      8'h24: return mBrg;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mMpc = 0; mPpc = 0; mPpcEn = 0; mMsc = 0; mMscEn = 0;
      mMscNs = 0; mBrg = 0; mPpcClr = 0; mMscClr = 0;
    end else begin
      pIn = 0;
      for (int i = 0; i < 10; i++) pIn[bpos(i)] = ppcIrqIn[i];
      cMask = 0; mPpcClr = 0; mMscClr = 0;
      if (regWen) begin
        case (regOffset)
          8'h08: begin
            cMask = regWdata & 32'h00F000F3;
            for (int i = 0; i < 10; i++) mPpcClr[i] = regWdata[bpos(i)];
          end
          8'h0C: mPpcEn = regWdata & 32'h00F000F3;
          8'h14: mMscClr = regWdata[19:16];
          8'h18: mMscEn = regWdata & 32'h000F0000;
          8'h1C: mMscNs = regWdata & 32'h000F0000;
          8'h24: mBrg = regWdata & 32'hFFFF0000;
          default: ;
        endcase
      end
      mPpc = pIn & ~cMask;
      mMpc = {12'h0, mpcExpIn, 14'h0, mpcIntIn};
      mMsc = {12'h0, mscExpIn, 16'h0};
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] modelEn();
    logic [9:0] e;
    for (int i = 0; i < 10; i++) e[i] = mPpcEn[bpos(i)];
    return e;
  endfunction

  // compare against the model on every clock
  initial forever begin
    @(negedge clk); #2;
    if (running) begin
      chk("R2/R3/R6/R11 rdata", regRdata, modelRead(regOffset));
      chk("R4 ppcClrOut", {22'h0, ppcClrOut}, {22'h0, mPpcClr});
      chk("R5 ppcEnOut", {22'h0, ppcEnOut}, {22'h0, modelEn()});
      chk("R8 mscClrOut", {28'h0, mscClrOut}, {28'h0, mMscClr});
      chk("R9 mscNsOut", {28'h0, mscNsOut}, {28'h0, mMscNs[19:16]});
      chk("R7 mscIrq", {31'h0, mscIrq}, {31'h0, |(mMsc & mMscEn)});
    end
  end

  task automatic wr(logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    regOffset = off; regWdata = d; regWen = 1'b1;
    @(negedge clk);
    regWen = 1'b0;
    #2;
  endtask

  task automatic rd(logic [7:0] off, logic [31:0] exp, string req);
    @(negedge clk);
    regOffset = off;
    #2;
    chk(req, regRdata, exp);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ppcEnOut", {22'h0, ppcEnOut}, 32'h0);
    chk("R1 mscIrq/ns", {27'h0, mscIrq, mscNsOut}, 32'h0);
    rst_n = 1'b1;
    running = 1'b1;
    rd(8'h00, 32'h0, "R1 mpc");
    rd(8'h0C, 32'h0, "R1 ppcEn");
    rd(8'h24, 32'h0, "R1 brgEn");

    // R2 packing
    mpcIntIn = 2'b10; mpcExpIn = 4'b0101;
    rd(8'h00, 32'h00050002, "R2 mpc sparse");
    mpcIntIn = 2'b01; mpcExpIn = 4'b1000;
    rd(8'h00, 32'h00080001, "R2 mpc walk");

    // R3 packing
    ppcIrqIn = 10'h3FF;
    rd(8'h04, 32'h00F000F3, "R3 ppc all");
    ppcIrqIn = 10'h040;
    rd(8'h04, 32'h00100000, "R3 ppc first ahb");
    ppcIrqIn = 10'h004;
    rd(8'h04, 32'h00000010, "R3 ppc first apb");

    // R4 clear with source still high
    ppcIrqIn = 10'h3FF;
    regOffset = 8'h04;
    wr(8'h08, 32'hFFFFFFFF);
    chk("R4 clr strobe", {22'h0, ppcClrOut}, 32'h3FF);
    regOffset = 8'h04; #1;
    chk("R4 status cleared", regRdata, 32'h0);
    @(negedge clk); #2;
    chk("R4 strobe one cycle", {22'h0, ppcClrOut}, 32'h0);
    wr(8'h08, 32'h0000000C);
    chk("R4 outside mask", {22'h0, ppcClrOut}, 32'h0);
    rd(8'h08, 32'h0, "R4 clr reads zero");
    ppcIrqIn = '0;

    // R5 enable
    wr(8'h0C, 32'hFFFFFFFF);
    rd(8'h0C, 32'h00F000F3, "R5 enable masked");
    wr(8'h0C, 32'h00100002);
    chk("R5 enable lines", {22'h0, ppcEnOut}, 32'h042);

    // R6/R7 bus-master status and combined irq
    mscExpIn = 4'b1010;
    rd(8'h10, 32'h000A0000, "R6 msc status");
    wr(8'h18, 32'h0002FFFF);
    rd(8'h18, 32'h00020000, "R7 enable stored");
    chk("R7 irq overlap", {31'h0, mscIrq}, 32'h1);
    wr(8'h18, 32'h00010000);
    chk("R7 irq no overlap", {31'h0, mscIrq}, 32'h0);

    // R8 clear strobes
    wr(8'h14, 32'h00050000);
    chk("R8 msc clr", {28'h0, mscClrOut}, 32'h5);
    @(negedge clk); #2;
    chk("R8 msc clr one cycle", {28'h0, mscClrOut}, 32'h0);
    rd(8'h14, 32'h0, "R8 reads zero");

    // R9 non-secure
    wr(8'h1C, 32'hFFFFFFFF);
    chk("R9 ns lines", {28'h0, mscNsOut}, 32'hF);
    rd(8'h1C, 32'h000F0000, "R9 ns read");

    // R10 bridge
    wr(8'h24, 32'hFFFFFFFF);
    rd(8'h24, 32'hFFFF0000, "R10 brg enable");
    wr(8'h20, 32'hFFFFFFFF);
    rd(8'h20, 32'h0, "R10 brg status");

    // R11 read-only and unmapped writes
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h30, 32'hFFFFFFFF);
    rd(8'h30, 32'h0, "R11 unmapped");
    rd(8'h0C, 32'h00100002, "R11 enable untouched");
    rd(8'h00, 32'h00080001, "R11 mpc untouched");

    repeat (4) @(negedge clk);
    running = 1'b0;
    finishRun();
  end
endmodule